// File: doc/BRIEF.md
# Microcontroller Interrupt Controller with Wake

This block gathers the interrupt sources of a small 8-bit microcontroller core and decides when the core must leave its current instruction stream. There are three sources. The first is an external pin with a selectable active edge. The second is a strobe from the timer that marks a wrap of the count. The third is a port-change detector. Each source has a sticky flag and its own enable bit. A global enable sits above all of them. All of these bits live in one 8-bit control register that the core reads and writes.

The core supplies a two-bit phase indicator that steps through four phases per instruction cycle, with the first phase encoded as 0. Pending requests are sampled once per instruction cycle, at the first phase. When a request is accepted, the block clears the global enable. It then flushes the pipeline for two dummy instruction cycles and raises a branch request that carries the fixed vector address. While the core reports that it is asleep, the block does not branch. Instead it raises a wake signal whenever any enabled flag is set, whatever the global enable holds. Once the core is awake again, the branch is taken only if the global enable is set.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and wake_o, flush_o and vec_req_o are low.
- R2: The control register holds these fields. Bits 0, 1 and 2 are the external, timer and port-change flags. Bits 3, 4 and 5 are the matching enables. Bit 6 selects the active edge of the external pin, where 1 means a low-to-high transition and 0 means a high-to-low transition. Bit 7 is the global enable. A transition of the opposite direction leaves the external flag clear.
- R3: A detected external edge sets the external flag only at a clock edge where phase_i is 3 or 0. An edge seen in phase 1 or 2 is held until the next such edge.
- R4: Flags are sticky, and no hardware event clears them. A register write sets each flag to the written bit. If a source sets a flag at the same edge as a write of 0 to it, the flag ends up set.
- R5: A high tmr_ovf_i sets the timer flag at the next edge, whatever the phase. The port-change flag is set whenever port_pins_i differs from a snapshot taken at each port_rd_i. This includes a change that arrives at the same edge as the read.
- R6: While asleep_i is high, wake_o is high exactly when some flag and its enable are both set. The global enable has no effect on wake_o.
- R7: A dispatch starts only at a clock edge where phase_i is 0. It requires the global enable, at least one flag with its enable set, and asleep_i low. If a flag's enable is clear, that flag causes no dispatch.
- R8: After a dispatch, flush_o is high for exactly 8 clocks, which is two instruction cycles. Then vec_req_o is high for exactly 4 clocks with vec_addr_o equal to 4. The global enable reads 0 after a dispatch.
- R9: No dispatch happens while asleep_i is high. When asleep_i falls, a pending enabled flag dispatches only if the global enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock, one edge per phase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 2 | Current phase within the instruction cycle; 0 is the first phase |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| tmr_ovf_i | input | 1 | Strobe marking a timer wrap |
| port_pins_i | input | PORT_W | Monitored port inputs |
| port_rd_i | input | 1 | Port read strobe; takes a snapshot of the port inputs |
| asleep_i | input | 1 | Core is in sleep |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register contents |
| wake_o | output | 1 | Wake request to a sleeping core |
| flush_o | output | 1 | Dummy-cycle flush during interrupt entry |
| vec_req_o | output | 1 | Branch request to the vector |
| vec_addr_o | output | ADDR_W | Vector address while vec_req_o is high, otherwise 0 |

## Verification
The bench builds the block with its default parameters. These are a four-bit port, a two-stage synchronizer, a 13-bit address and vector 4. The narrow port lets every single-pin change be swept. Every combination of global enable, enable mask and source is driven through the dispatch path, which makes 48 cases. The exact flush and branch lengths are counted in each case. The bench also steps the timer strobe through all four phases and sweeps both edge selections against both pin directions. It exercises the wake path with the global enable both clear and set.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_DUMMY1, SEQ_DUMMY2, SEQ_VEC} seq_e;
  localparam int N_SRC    = 3;
  localparam int FLAG_LSB = 0;
  localparam int EN_LSB   = FLAG_LSB + N_SRC;
  localparam int EDGE_BIT = EN_LSB + N_SRC;
  localparam int GIE_BIT  = EDGE_BIT + 1;
  localparam int REG_W    = GIE_BIT + 1;
  localparam int SRC_EXT  = 0;
  localparam int SRC_TMR  = 1;
  localparam int SRC_CHG  = 2;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  input  logic window_i,
  output logic hit_o
);
  localparam int CW = SYNC_STAGES + 1;
  logic [CW-1:0] chain_q;
  logic          pend_q;
  logic          edge_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[CW-2:0], pin_i};
  end

  assign edge_seen = rise_sel_i ? ( chain_q[CW-2] & ~chain_q[CW-1])
                                : (~chain_q[CW-2] &  chain_q[CW-1]);

  // edge outside the set window is parked until the window opens
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q | edge_seen) & ~window_i;
  end

  assign hit_o = window_i & (pend_q | edge_seen);

  assert_pend_drains_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    window_i |=> !pend_q);
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_wake_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             dispatch_i,
  output logic [REG_W-1:0] ctrl_o
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (we_i) ctrl_q[REG_W-1:EN_LSB] <= wdata_i[REG_W-1:EN_LSB];
      if (dispatch_i) ctrl_q[GIE_BIT] <= 1'b0;
      // hardware set dominates a software clear
      ctrl_q[FLAG_LSB +: N_SRC] <= (we_i ? wdata_i[FLAG_LSB +: N_SRC]
                                          : ctrl_q[FLAG_LSB +: N_SRC]) | set_i;
    end
  end

  assign ctrl_o = ctrl_q;

  for (genvar k = 0; k < N_SRC; k++) begin : g_chk
    assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> ctrl_q[FLAG_LSB + k]);
    assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[FLAG_LSB + k] && !we_i) |=> ctrl_q[FLAG_LSB + k]);
  end

  assert_gie_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_i |=> !ctrl_q[GIE_BIT]);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_wake_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic q1_i,
  input  logic req_i,
  output logic dispatch_o,
  output logic flush_o,
  output logic vec_req_o
);
  seq_e st_q;

  assign dispatch_o = (st_q == SEQ_IDLE) & q1_i & req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SEQ_IDLE;
    end else if (q1_i) begin
      unique case (st_q)
        SEQ_IDLE:   if (req_i) st_q <= SEQ_DUMMY1;
        SEQ_DUMMY1: st_q <= SEQ_DUMMY2;
        SEQ_DUMMY2: st_q <= SEQ_VEC;
        default:    st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign flush_o   = (st_q == SEQ_DUMMY1) | (st_q == SEQ_DUMMY2);
  assign vec_req_o = (st_q == SEQ_VEC);

  assert_vec_follows_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flush_o) |-> vec_req_o);
  assert_flush_after_dispatch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_o |=> flush_o);
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 13,
  parameter int VEC_ADDR    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        phase_i,
  input  logic              ext_pin_i,
  input  logic              tmr_ovf_i,
  input  logic [PORT_W-1:0] port_pins_i,
  input  logic              port_rd_i,
  input  logic              asleep_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              wake_o,
  output logic              flush_o,
  output logic              vec_req_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  logic [REG_W-1:0]  ctrl;
  logic [N_SRC-1:0]  set_src;
  logic [PORT_W-1:0] snap_q;
  logic              window, q1, ext_hit, pending, req, dispatch;

  assign q1     = (phase_i == PH_Q1);
  assign window = (phase_i == PH_Q4) | q1;

  irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .pin_i(ext_pin_i), .rise_sel_i(ctrl[EDGE_BIT]),
    .window_i(window), .hit_o(ext_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (port_rd_i) snap_q <= port_pins_i;
  end

  assign set_src[SRC_EXT] = ext_hit;
  assign set_src[SRC_TMR] = tmr_ovf_i;
  assign set_src[SRC_CHG] = |(port_pins_i ^ snap_q);

  irq_flags u_flags (
    .clk_i, .rst_ni, .set_i(set_src), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .dispatch_i(dispatch), .ctrl_o(ctrl));

  assign pending = |(ctrl[FLAG_LSB +: N_SRC] & ctrl[EN_LSB +: N_SRC]);
  assign req     = ctrl[GIE_BIT] & pending & ~asleep_i;
  assign wake_o  = asleep_i & pending;

  irq_entry_seq u_seq (
    .clk_i, .rst_ni, .q1_i(q1), .req_i(req),
    .dispatch_o(dispatch), .flush_o(flush_o), .vec_req_o(vec_req_o));

  assign vec_addr_o  = vec_req_o ? ADDR_W'(VEC_ADDR) : '0;
  assign reg_rdata_o = ctrl;

  assert_ext_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl[FLAG_LSB + SRC_EXT]) && !$past(reg_we_i)) |->
      ($past(phase_i) == PH_Q4 || $past(phase_i) == PH_Q1));
  assert_entry_on_q1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flush_o) |-> ($past(phase_i) == PH_Q1 && $past(ctrl[GIE_BIT])));
  assert_no_entry_asleep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flush_o) |-> !$past(asleep_i));
  assert_wake_only_asleep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep_i && $stable(ctrl) && pending) |-> wake_o);
endmodule

// File: tb/irq_wake_ctrl_tb.sv
module irq_wake_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ph = 2'd0;
  logic ext_pin = 1'b0, tmr = 1'b0, prd = 1'b0, asleep = 1'b0, we = 1'b0;
  logic [PW-1:0] pins = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic wake, flush, vreq;
  logic [12:0] vaddr;
  int checks = 0, fails = 0;
  logic we_at_edge = 1'b0;
  logic prev_ext_f = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ph <= ph + 2'd1;
  always @(posedge clk) we_at_edge <= we;

  irq_wake_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(ph), .ext_pin_i(ext_pin), .tmr_ovf_i(tmr),
    .port_pins_i(pins), .port_rd_i(prd), .asleep_i(asleep), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wake_o(wake), .flush_o(flush),
    .vec_req_o(vreq), .vec_addr_o(vaddr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3: phase seen at the edge that set the external flag
  always @(negedge clk) begin
    if (rst_n && !prev_ext_f && rdata[0] && !we_at_edge)
      chk((ph - 2'd1) == 2'd3 || (ph - 2'd1) == 2'd0, "R3 ext flag set phase",
          int'(ph - 2'd1), 0);
    prev_ext_f <= rdata[0];
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic port_read();
    @(negedge clk); prd = 1'b1;
    @(negedge clk); prd = 1'b0;
  endtask

  task automatic observe(input int n, output int fl, output int vc, output bit addr_ok,
                         output int first_ph);
    fl = 0; vc = 0; addr_ok = 1'b1; first_ph = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (flush) begin
        if (fl == 0) first_ph = int'(ph - 2'd1);
        fl++;
      end
      if (vreq) begin
        vc++;
        if (vaddr != 13'd4) addr_ok = 1'b0;
      end else if (vaddr != 13'd0) addr_ok = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int fl, vc, fph;
    bit aok;
    idle(3);
    chk(rdata == 8'h00, "R1 reset register", rdata, 0);
    chk(!wake && !flush && !vreq, "R1 reset outputs", {wake, flush, vreq}, 0);
    rst_n = 1'b1;
    idle(2);

    // R2: edge polarity sweep
    for (int sel = 0; sel < 2; sel++) begin
      wr(8'(sel << 6));
      ext_pin = 1'b1; idle(10);
      chk(rdata[0] == sel[0], "R2 low-to-high edge", rdata[0], sel);
      wr(8'(sel << 6));
      ext_pin = 1'b0; idle(10);
      chk(rdata[0] == !sel[0], "R2 high-to-low edge", rdata[0], !sel[0]);
      wr(8'(sel << 6));
    end
    wr(8'h00);

    // R5: timer strobe in every phase
    for (int p = 0; p < 4; p++) begin
      do @(negedge clk); while (ph != 2'(p));
      tmr = 1'b1;
      @(negedge clk); tmr = 1'b0;
      chk(rdata[1], "R5 timer flag set in phase", rdata[1], 1);
      wr(8'h00);
      chk(!rdata[1], "R4 software clear", rdata[1], 0);
    end

    // R4: set wins over same-edge clear, then stays sticky
    @(negedge clk); we = 1'b1; wdata = 8'h00; tmr = 1'b1;
    @(negedge clk); we = 1'b0; tmr = 1'b0;
    chk(rdata[1], "R4 set beats clear", rdata[1], 1);
    idle(30);
    chk(rdata[1], "R4 flag sticky", rdata[1], 1);
    wr(8'h00);

    // R5: port change on every pin, snapshot on read
    for (int i = 0; i < PW; i++) begin
      pins = PW'(1 << i); idle(2);
      chk(rdata[2], "R5 port change sets flag", rdata[2], 1);
      port_read(); wr(8'h00); idle(2);
      chk(!rdata[2], "R5 snapshot match keeps flag clear", rdata[2], 0);
      pins = '0; idle(2);
      chk(rdata[2], "R5 return change sets flag", rdata[2], 1);
      port_read(); wr(8'h00);
    end
    @(negedge clk); pins = 4'b1010; prd = 1'b1;
    @(negedge clk); prd = 1'b0;
    chk(rdata[2], "R5 change coinciding with read", rdata[2], 1);
    wr(8'h00); idle(2);
    chk(!rdata[2], "R5 snapshot took coinciding value", rdata[2], 0);
    pins = '0; port_read(); wr(8'h00);

    // R7 R8: full sweep of gie x enable mask x source
    for (int g = 0; g < 2; g++)
      for (int en = 0; en < 8; en++)
        for (int s = 0; s < 3; s++) begin
          bit expd;
          expd = (g == 1) && en[s];
          wr(8'((g << 7) | (en << 3) | (1 << s)));
          observe(24, fl, vc, aok, fph);
          chk(fl == (expd ? 8 : 0), "R7 R8 flush length", fl, expd ? 8 : 0);
          chk(vc == (expd ? 4 : 0) && aok, "R8 vector request and address", vc, expd ? 4 : 0);
          if (expd) chk(fph == 0, "R7 dispatch phase", fph, 0);
          chk(rdata[7] == (g == 1 && !expd), "R8 global enable after entry", rdata[7],
              (g == 1 && !expd));
          wr(8'h00);
        end

    // R6 R9: sleep and wake
    asleep = 1'b1;
    for (int s = 0; s < 3; s++)
      for (int on = 0; on < 2; on++) begin
        wr(8'((on << (3 + s)) | (1 << s)));
        idle(2);
        chk(wake == on[0], "R6 wake follows enabled flag", wake, on);
        observe(12, fl, vc, aok, fph);
        chk(fl == 0 && vc == 0, "R9 no entry while asleep", fl, 0);
      end
    wr(8'h88 | 8'h01);
    idle(2);
    chk(wake, "R6 wake with global enable set", wake, 1);
    observe(12, fl, vc, aok, fph);
    chk(fl == 0, "R9 global enable set but asleep", fl, 0);
    @(negedge clk); asleep = 1'b0;
    observe(24, fl, vc, aok, fph);
    chk(fl == 8 && vc == 4, "R9 entry after wake with global enable", fl, 8);
    wr(8'h00);
    asleep = 1'b1;
    wr(8'h09);
    idle(2);
    chk(wake, "R6 wake with global enable clear", wake, 1);
    @(negedge clk); asleep = 1'b0;
    observe(24, fl, vc, aok, fph);
    chk(fl == 0 && vc == 0, "R9 no entry after wake without global enable", fl, 0);
    chk(!wake, "R6 wake low when awake", wake, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule